// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Slave

This block decodes the slave side of a three-pin serial register bus. The pins are an active-low select, a bus clock and one shared data line. A transaction opens with a 9-bit header that names a device, a direction and a register. A 16-bit data phase follows. On a write, the block collects the data from the line. On a read, it takes the data line over and shifts the register value out. The bus pins are asynchronous to the system clock. They pass through a synchronizer, and the block detects their edges in the system clock domain.

On the core side there is a plain register-access port. It carries device, index, direction and write data, together with a one-cycle strobe. The read value comes back on a separate input one cycle after a read strobe. The block serves one device address, set by a parameter. A header that names any other device raises a one-cycle error pulse and leaves the port and the data line untouched.

Top module: `sbus_slave`

## Requirements
- R1: A rising bus-clock edge counts only while select is low. While select is high, clock and data activity produces no strobe and no error pulse.
- R2: Raising select and lowering it again abandons a partial header or data phase. No access is issued for the abandoned transaction, and the next transaction is decoded from its first header bit.
- R3: Header bits arrive MSB first. Header bits 8..6 give the device address, bit 5 gives the direction (1 = read, 0 = write) and bits 4..0 give the register index.
- R4: A read header for the own device pulses `reg_strobe_o` with `reg_rw_o`=1 as soon as the header completes, before any data edge. The value on `reg_rdata_i` in the strobe cycle is then driven on `bus_dat_o` MSB first, one new bit per rising bus-clock edge.
- R5: On a write, 16 data bits are sampled MSB first. `reg_strobe_o` with `reg_rw_o`=0 and the assembled `reg_wdata_o` is issued only after the 16th bit has been received.
- R6: After the data phase the block returns to the header phase by itself, so further transactions can follow without deasserting select.
- R7: A header whose device field differs from `DEV_ADDR` pulses `addr_err_o` for one cycle and causes no strobe. On a read it drives nothing for that transaction.
- R8: `bus_dat_oe_o` rises only with a read strobe. It stays high through the read data phase and drops at the first rising bus-clock edge after the 16th bit, or once select is high. `bus_dat_o` is 0 whenever the enable is low.
- R9: During reset and right after it, `reg_strobe_o`, `addr_err_o`, `bus_dat_oe_o` and `bus_dat_o` are all 0.
- R10: `reg_strobe_o` is high for exactly one system clock per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_ni | input | 1 | Bus select, active low, asynchronous |
| bus_clk_i | input | 1 | Bus clock, asynchronous |
| bus_dat_i | input | 1 | Shared data line, input side |
| bus_dat_o | output | 1 | Shared data line, output value |
| bus_dat_oe_o | output | 1 | Output enable for the shared data line |
| reg_dev_o | output | 3 | Device address of the current access |
| reg_idx_o | output | 5 | Register index of the current access |
| reg_rw_o | output | 1 | Access direction, 1 = read |
| reg_strobe_o | output | 1 | One-cycle access strobe |
| reg_wdata_o | output | 16 | Write data, valid with a write strobe |
| reg_rdata_i | input | 16 | Read data, sampled in the read strobe cycle |
| addr_err_o | output | 1 | One-cycle pulse on a foreign device header |

## Verification
A bit counter or phase that is off by one shows up at the ports within a single transaction. The strobe then arrives an edge early or late against the scoreboard, the write data comes out shifted, or read bits land in the wrong positions in the sampled word. Framing left over from an abandoned or back-to-back transaction shows in the next header as a wrong index or a missing strobe. A wrong device match shows at once as an unexpected strobe or a missing error pulse. An enable that stays asserted shows as a driven line during a write phase or after select is released.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  parameter int DEV_W  = 3;
  parameter int IDX_W  = 5;
  parameter int DATA_W = 16;
  localparam int HDR_W = DEV_W + 1 + IDX_W;
  localparam int CNT_W = $clog2((DATA_W > HDR_W) ? DATA_W : HDR_W);

  typedef enum logic {PH_HDR, PH_DAT} phase_e;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic             rd;
    logic [IDX_W-1:0] idx;
  } hdr_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sbus_edge.sv
module sbus_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_s_i,
  input  logic sel_s_i,
  output logic rise_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else bclk_q <= bclk_s_i;
  end

  // edges count only while select is active
  assign rise_o = bclk_s_i & ~bclk_q & ~sel_s_i;
endmodule

// File: rtl/sbus_engine.sv
module sbus_engine
  import sbus_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR = 3'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_s_i,
  input  logic              rise_i,
  input  logic              dat_s_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              dat_o,
  output logic              oe_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rw_o,
  output logic              strobe_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              match_q;
  hdr_t              hdr;
  logic              hit;

  assign hdr = hdr_t'({shreg_q[HDR_W-2:0], dat_s_i});
  assign hit = (hdr.dev == DEV_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_HDR;
      cnt_q    <= HDR_LAST;
      shreg_q  <= '0;
      match_q  <= 1'b0;
      dat_o    <= 1'b0;
      oe_o     <= 1'b0;
      dev_o    <= '0;
      idx_o    <= '0;
      rw_o     <= 1'b0;
      strobe_o <= 1'b0;
      wdata_o  <= '0;
      err_o    <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      err_o    <= 1'b0;
      if (sel_s_i) begin
        phase_q <= PH_HDR;
        cnt_q   <= HDR_LAST;
        shreg_q <= '0;
        oe_o    <= 1'b0;
        dat_o   <= 1'b0;
      end else begin
        // read fetch lands one cycle after header; no edge can fall here
        if (strobe_o && rw_o) shreg_q <= rdata_i;
        if (rise_i) begin
          unique case (phase_q)
            PH_HDR: begin
              oe_o  <= 1'b0;
              dat_o <= 1'b0;
              if (cnt_q == '0) begin
                dev_o   <= hdr.dev;
                idx_o   <= hdr.idx;
                rw_o    <= hdr.rd;
                match_q <= hit;
                phase_q <= PH_DAT;
                cnt_q   <= DAT_LAST;
                shreg_q <= '0;
                if (hit) begin
                  strobe_o <= hdr.rd;
                  oe_o     <= hdr.rd;
                end else begin
                  err_o <= 1'b1;
                end
              end else begin
                shreg_q <= {shreg_q[DATA_W-2:0], dat_s_i};
                cnt_q   <= cnt_q - 1'b1;
              end
            end
            PH_DAT: begin
              if (rw_o) begin
                if (match_q) dat_o <= shreg_q[DATA_W-1];
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
              end else begin
                shreg_q <= {shreg_q[DATA_W-2:0], dat_s_i};
              end
              if (cnt_q == '0) begin
                phase_q <= PH_HDR;
                cnt_q   <= HDR_LAST;
                shreg_q <= '0;
                if (!rw_o && match_q) begin
                  strobe_o <= 1'b1;
                  wdata_o  <= {shreg_q[DATA_W-2:0], dat_s_i};
                end
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
  import sbus_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR    = 3'd1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_ni,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  output logic              bus_dat_o,
  output logic              bus_dat_oe_o,
  output logic [DEV_W-1:0]  reg_dev_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              reg_rw_o,
  output logic              reg_strobe_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              addr_err_o
);
  logic sel_s, bclk_s, dat_s, rise;

  // reset view: select inactive, clock and data low
  sbus_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_sel_ni, bus_clk_i, bus_dat_i}),
    .q_o    ({sel_s, bclk_s, dat_s})
  );

  sbus_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_s_i (bclk_s),
    .sel_s_i  (sel_s),
    .rise_o   (rise)
  );

  sbus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_s_i  (sel_s),
    .rise_i   (rise),
    .dat_s_i  (dat_s),
    .rdata_i  (reg_rdata_i),
    .dat_o    (bus_dat_o),
    .oe_o     (bus_dat_oe_o),
    .dev_o    (reg_dev_o),
    .idx_o    (reg_idx_o),
    .rw_o     (reg_rw_o),
    .strobe_o (reg_strobe_o),
    .wdata_o  (reg_wdata_o),
    .err_o    (addr_err_o)
  );
endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk
  import sbus_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR    = 3'd1,
  parameter int               SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_sel_ni,
  input logic             bus_dat_o,
  input logic             bus_dat_oe_o,
  input logic [DEV_W-1:0] reg_dev_o,
  input logic             reg_rw_o,
  input logic             reg_strobe_o,
  input logic             addr_err_o
);
  p_strobe_own_dev_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_strobe_o |-> reg_dev_o == DEV_ADDR);

  p_err_no_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> !reg_strobe_o);

  p_strobe_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_strobe_o |=> !reg_strobe_o);

  p_oe_on_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dat_oe_o |-> reg_rw_o);

  p_dat_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_dat_oe_o |-> !bus_dat_o);

  p_oe_starts_with_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_dat_oe_o) |-> reg_strobe_o && reg_rw_o);

  p_sel_high_drops_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_sel_ni, SYNC_STAGES + 1) |-> !bus_dat_oe_o);
endmodule

bind sbus_slave sbus_slave_chk #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_sel_ni   (bus_sel_ni),
  .bus_dat_o    (bus_dat_o),
  .bus_dat_oe_o (bus_dat_oe_o),
  .reg_dev_o    (reg_dev_o),
  .reg_rw_o     (reg_rw_o),
  .reg_strobe_o (reg_strobe_o),
  .addr_err_o   (addr_err_o)
);

// File: tb/tb_sbus_slave.sv
module tb_sbus_slave;
  localparam int HALF = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_ni = 1'b1;
  logic        bus_clk_i = 1'b0;
  logic        bus_dat_i = 1'b0;
  logic        bus_dat_o, bus_dat_oe_o, reg_rw_o, reg_strobe_o, addr_err_o;
  logic [2:0]  reg_dev_o;
  logic [4:0]  reg_idx_o;
  logic [15:0] reg_wdata_o, reg_rdata_i;

  typedef struct packed {
    logic        rw;
    logic [2:0]  dev;
    logic [4:0]  idx;
    logic [15:0] data;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int err_seen = 0;
  int err_exp = 0;
  int strobes = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [15:0] rd_model(input logic [4:0] i);
    return 16'hC3A5 ^ {i, 6'b0, i};
  endfunction

  assign reg_rdata_i = rd_model(reg_idx_o);

  sbus_slave dut (
    .clk_i, .rst_ni, .bus_sel_ni, .bus_clk_i, .bus_dat_i,
    .bus_dat_o, .bus_dat_oe_o, .reg_dev_o, .reg_idx_o, .reg_rw_o,
    .reg_strobe_o, .reg_wdata_o, .reg_rdata_i, .addr_err_o
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && addr_err_o) err_seen++;
    if (rst_ni && reg_strobe_o) begin
      strobes++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R1/R5 unexpected strobe", {reg_rw_o, reg_dev_o, reg_idx_o}, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check({reg_rw_o, reg_dev_o, reg_idx_o} == {it.rw, it.dev, it.idx},
              "R3 strobe fields", {reg_rw_o, reg_dev_o, reg_idx_o}, {it.rw, it.dev, it.idx});
        if (!it.rw)
          check(reg_wdata_o == it.data, "R5 write data", reg_wdata_o, it.data);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic bus_bit(input logic d);
    bus_clk_i = 1'b0;
    bus_dat_i = d;
    wait_clk(HALF);
    bus_clk_i = 1'b1;
    wait_clk(HALF);
    #3;
  endtask

  task automatic xfer(input logic [2:0] dev, input logic rw, input logic [4:0] idx,
                      input logic [15:0] wd, input bit hit);
    logic [8:0]  hdr;
    logic [15:0] rd;
    int          oe_bad;
    int          s0;
    hdr = {dev, rw, idx};
    oe_bad = 0;
    for (int i = 8; i >= 0; i--) begin
      if (i == 0 && hit && rw) sb_q.push_back({rw, dev, idx, 16'h0});
      s0 = strobes;
      bus_bit(hdr[i]);
    end
    if (hit && rw) check(strobes == s0 + 1, "R4 read strobe before data", strobes, s0 + 1);
    rd = '0;
    for (int i = 15; i >= 0; i--) begin
      if (i == 0 && hit && !rw) sb_q.push_back({rw, dev, idx, wd});
      if (i == 0 && hit && !rw)
        check(sb_q.size() == 1, "R5 no early write strobe", sb_q.size(), 1);
      bus_bit(rw ? 1'b0 : wd[i]);
      rd[i] = bus_dat_o;
      if (bus_dat_oe_o !== (hit && rw)) oe_bad++;
      if (!bus_dat_oe_o && bus_dat_o) oe_bad++;
    end
    check(oe_bad == 0, "R8 output enable in data phase", oe_bad, 0);
    if (hit && rw) check(rd == rd_model(idx), "R4 read data", rd, rd_model(idx));
    if (!hit) begin
      err_exp++;
      wait_clk(2);
      check(err_seen == err_exp, "R7 error pulse", err_seen, err_exp);
    end
  endtask

  task automatic sel(input logic v);
    bus_sel_ni = v;
    wait_clk(HALF);
    #3;
  endtask

  initial begin
    wait_clk(5);
    #3;
    check(!reg_strobe_o && !addr_err_o && !bus_dat_oe_o && !bus_dat_o, "R9 reset outputs",
          {reg_strobe_o, addr_err_o, bus_dat_oe_o, bus_dat_o}, 0);
    rst_ni = 1'b1;
    wait_clk(4);
    #3;
    check(!reg_strobe_o && !addr_err_o && !bus_dat_oe_o && !bus_dat_o, "R9 after reset",
          {reg_strobe_o, addr_err_o, bus_dat_oe_o, bus_dat_o}, 0);

    // R1: activity with select high
    for (int i = 0; i < 25; i++) bus_bit(i[0] ? 1'b1 : 1'b0);
    check(strobes == 0 && err_seen == 0, "R1 ignored while deselected", strobes + err_seen, 0);

    // R3 R5 single write, R4 single read
    sel(1'b0);
    xfer(3'd1, 1'b0, 5'h0A, 16'hBEEF, 1'b1);
    sel(1'b1);
    sel(1'b0);
    xfer(3'd1, 1'b1, 5'h13, 16'h0, 1'b1);
    check(bus_dat_oe_o == 1'b1, "R8 enable held after last bit", bus_dat_oe_o, 1);
    sel(1'b1);
    check(bus_dat_oe_o == 1'b0 && bus_dat_o == 1'b0, "R8 enable off after deselect",
          {bus_dat_oe_o, bus_dat_o}, 0);

    // R6 back to back
    sel(1'b0);
    xfer(3'd1, 1'b0, 5'h03, 16'h1234, 1'b1);
    xfer(3'd1, 1'b1, 5'h05, 16'h0, 1'b1);
    xfer(3'd1, 1'b0, 5'h1F, 16'h8001, 1'b1);
    xfer(3'd1, 1'b1, 5'h00, 16'h0, 1'b1);
    sel(1'b1);
    check(sb_q.size() == 0, "R6 all back-to-back accesses issued", sb_q.size(), 0);

    // R7 foreign device
    sel(1'b0);
    xfer(3'd5, 1'b1, 5'h02, 16'h0, 1'b0);
    xfer(3'd0, 1'b0, 5'h02, 16'hFFFF, 1'b0);
    xfer(3'd1, 1'b0, 5'h11, 16'h5AA5, 1'b1);
    sel(1'b1);

    // R2 abort partial header and partial data
    sel(1'b0);
    for (int i = 0; i < 5; i++) bus_bit(1'b1);
    sel(1'b1);
    sel(1'b0);
    xfer(3'd1, 1'b0, 5'h07, 16'h00FF, 1'b1);
    sel(1'b1);
    sel(1'b0);
    for (int i = 8; i >= 0; i--) bus_bit(i == 6 ? 1'b1 : 1'b0);
    for (int i = 0; i < 8; i++) bus_bit(1'b1);
    sel(1'b1);
    sel(1'b0);
    xfer(3'd1, 1'b1, 5'h1A, 16'h0, 1'b1);
    sel(1'b1);
    wait_clk(4);
    check(sb_q.size() == 0, "R2 queue drained", sb_q.size(), 0);
    check(strobes == 9, "R2 R10 strobe count", strobes, 9);
    check(err_seen == 2, "R7 total errors", err_seen, 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_clk(150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule